// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block watches a parallel NOR flash while it runs an embedded program or erase operation and reports when that operation has finished. Once started, it holds chip enable low, presents a fixed status address and pulses output enable to take a stream of status reads. On each read it compares the toggle bit (data bit 6) with the value it saw on the previous read. While the device is busy the bit flips on every read. Two equal reads in a row mean the operation is over.

All pulse spacing is counted in system clocks and derived from nanosecond parameters. The address is set up before output enable falls, output enable stays high between reads for the required minimum, and data is captured after a configurable access time. When the toggle bit keeps flipping and the device also raises its fault bit (data bit 5), the block takes a fixed number of confirmation reads before it decides between success and failure. The ready/busy line is treated as an early completion hint only after its start-up window has passed. A timeout that depends on the operation type stops polling when the device never settles.

The caller presents the status address and the operation type together with a one-cycle `start`. It then waits for `busy` to fall and reads exactly one of `done`, `error` or `timeout`.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is applied and after it is released with no start, flashCeN and flashOeN are 1 and busy, done, error and timeout are 0.
- R2: A start while idle latches pollAddr and opBuffer, clears all three result flags and sets busy. flashAddr then holds the latched address for the whole operation, and a start seen while busy changes neither the address nor the operation type.
- R3: flashCeN falls on the clock after the accepted start, and the first falling edge of flashOeN comes 2 clock cycles later (2 cycles of 8 ns cover the 15 ns address setup).
- R4: flashCeN stays low for the whole operation, flashOeN is never low while flashCeN is high, and between two reads flashOeN stays high for at least 3 cycles (covering 20 ns).
- R5: Each read holds flashOeN low for 4 cycles (the output-enable delay of 25 ns rounded up). dqIn is captured on the 4th rising edge after flashOeN falls, so with the defaults read k (from 0) is captured on edge 6+7k after the start edge.
- R6: When two consecutive captured reads have equal dqIn[6], done is set on the edge of the second capture, and flashCeN, flashOeN and busy return to 1, 1 and 0 on that same edge. All bits other than 6 and 5 have no effect.
- R7: If dqIn[6] toggles on a read whose dqIn[5] is 1, two more reads follow. If either of them matches its predecessor in bit 6, done is set. If both toggle, error is set instead, on the edge that captures the second extra read.
- R8: rdyBusyN passes a two-stage synchronizer and is ignored on the first 12 edges after the start edge (90 ns window). From edge 13 on, a synchronized high ends the operation with done.
- R9: If no result arrives first, timeout is set on edge 21875 after the start edge for opBuffer=0 (175 us) or on edge 31250 for opBuffer=1 (250 us), and flashCeN and flashOeN return high.
- R10: At most one of done, error and timeout is 1. The flag that ends an operation stays set until the next accepted start, and busy never falls without one of them set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (8 ns by default) |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| opBuffer | input | 1 | Operation type: 0 single-word program, 1 buffer program |
| pollAddr | input | ADDR_W | Status read address, latched at start |
| dqIn | input | DATA_W | Flash data bus |
| rdyBusyN | input | 1 | Flash ready/busy line, low while busy |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashAddr | output | ADDR_W | Flash address |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Operation completed |
| error | output | 1 | Operation failed (fault bit with persistent toggling) |
| timeout | output | 1 | Operation exceeded its time limit |

## Verification
The bench goes after exact completion edges. A poller that treats the very first read as a comparison, or that drops one read, ends 7 cycles early or late. The fault path is driven both with a device that settles on the last confirmation read and with one that never settles. A design with an off-by-one in the confirmation count reports error for a recoverable device or done for a failed one. Ready/busy is held high from before the start to show that a missing ignore window ends the operation within a few cycles. A stray start in mid-operation, together with the word-length timeout, catches a design that relatches the address or the operation type.

// File: rtl/tpoll_pkg.sv
`timescale 1ns/1ps
package tpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_READ  = 2'd2,
    ST_GAP   = 2'd3
  } pollState_t;

  typedef enum logic [1:0] {
    VERD_WAIT  = 2'd0,
    VERD_DONE  = 2'd1,
    VERD_FAULT = 2'd2
  } verdict_t;

  typedef struct packed {
    logic launch;
    logic running;
    logic sample;
    logic finDone;
    logic finError;
    logic finTimeout;
  } dpStrobe_t;

  function automatic int cyclesFor(input longint timePs, input longint periodPs);
    longint c;
    c = (timePs + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/tpoll_datapath.sv
`timescale 1ns/1ps
module tpoll_datapath
  import tpoll_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 16,
  parameter int TOGGLE_BIT    = 6,
  parameter int FAULT_BIT     = 5,
  parameter int CONFIRM_READS = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int IGN_CYC       = 12,
  parameter int TO_WORD_CYC   = 21875,
  parameter int TO_BUF_CYC    = 31250,
  parameter int TO_W          = 15,
  parameter int IGN_W         = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              opBuffer,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              rdyBusyN,
  output logic [ADDR_W-1:0] flashAddr,
  output verdict_t          verdict,
  output logic              rdyValid,
  output logic              toExpire,
  output logic              done,
  output logic              error,
  output logic              timeout
);

  localparam int CONF_W = $clog2(CONFIRM_READS + 1);

  logic [ADDR_W-1:0]      addrQ;
  logic                   opBufQ;
  logic [TO_W-1:0]        toCnt;
  logic [TO_W-1:0]        toLimit;
  logic [IGN_W-1:0]       ignCnt;
  logic [SYNC_STAGES-1:0] rdySyncQ;
  logic                   prevBit;
  logic                   havePrev;
  logic                   confirmOn;
  logic [CONF_W-1:0]      confirmLeft;
  logic                   curBit;
  logic                   toggled;

  // request latch: address and operation type are frozen for the operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      opBufQ <= 1'b0;
    end else if (stb.launch) begin
      addrQ  <= pollAddr;
      opBufQ <= opBuffer;
    end
  end

  assign flashAddr = addrQ;

  // ready/busy synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdySyncQ <= '0;
    else       rdySyncQ <= {rdySyncQ[SYNC_STAGES-2:0], rdyBusyN};
  end

  // timeout counter, limit picked by the latched operation type
  assign toLimit  = opBufQ ? TO_W'(TO_BUF_CYC - 1) : TO_W'(TO_WORD_CYC - 1);
  assign toExpire = stb.running && (toCnt == toLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            toCnt <= '0;
    else if (stb.launch)  toCnt <= '0;
    else if (stb.running) toCnt <= toCnt + 1'b1;
  end

  // ignore window for the ready/busy line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          ignCnt <= '0;
    else if (stb.launch)                                ignCnt <= '0;
    else if (stb.running && ignCnt != IGN_W'(IGN_CYC))  ignCnt <= ignCnt + 1'b1;
  end

  assign rdyValid = stb.running && (ignCnt == IGN_W'(IGN_CYC)) && rdySyncQ[SYNC_STAGES-1];

  // toggle comparison against the previous capture
  assign curBit  = dqIn[TOGGLE_BIT];
  assign toggled = havePrev && (curBit != prevBit);

  always_comb begin
    if (!havePrev)                                         verdict = VERD_WAIT;
    else if (!toggled)                                     verdict = VERD_DONE;
    else if (confirmOn && confirmLeft == CONF_W'(1))       verdict = VERD_FAULT;
    else                                                   verdict = VERD_WAIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit     <= 1'b0;
      havePrev    <= 1'b0;
      confirmOn   <= 1'b0;
      confirmLeft <= '0;
    end else if (stb.launch) begin
      prevBit     <= 1'b0;
      havePrev    <= 1'b0;
      confirmOn   <= 1'b0;
      confirmLeft <= '0;
    end else if (stb.sample) begin
      prevBit  <= curBit;
      havePrev <= 1'b1;
      if (toggled) begin
        if (confirmOn) begin
          confirmLeft <= confirmLeft - 1'b1;
        end else if (dqIn[FAULT_BIT]) begin
          confirmOn   <= 1'b1;
          confirmLeft <= CONF_W'(CONFIRM_READS);
        end
      end
    end
  end

  // result flags, held until the next launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      error   <= 1'b0;
      timeout <= 1'b0;
    end else if (stb.launch) begin
      done    <= 1'b0;
      error   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (stb.finDone)    done    <= 1'b1;
      if (stb.finError)   error   <= 1'b1;
      if (stb.finTimeout) timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/tpoll_ctrl.sv
`timescale 1ns/1ps
module tpoll_ctrl
  import tpoll_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int ACCESS_CYC = 4,
  parameter int HIGH_CYC   = 3,
  parameter int PHASE_W    = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  verdict_t  verdict,
  input  logic      rdyValid,
  input  logic      toExpire,
  output dpStrobe_t stb,
  output logic      flashCeN,
  output logic      flashOeN,
  output logic      busy
);

  pollState_t       state, stateNext;
  logic [PHASE_W-1:0] phaseCnt, phaseNext;
  logic             samplePoint;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseNext;
    end
  end

  assign samplePoint = (state == ST_READ) && (phaseCnt == PHASE_W'(ACCESS_CYC - 1));

  always_comb begin
    stateNext = state;
    phaseNext = phaseCnt;
    stb       = '0;
    stb.running = (state != ST_IDLE);
    stb.sample  = samplePoint;

    if (state == ST_IDLE) begin
      if (start) begin
        stb.launch = 1'b1;
        stateNext  = ST_SETUP;
        phaseNext  = '0;
      end
    end else if (samplePoint && verdict == VERD_DONE) begin
      stb.finDone = 1'b1;
      stateNext   = ST_IDLE;
      phaseNext   = '0;
    end else if (samplePoint && verdict == VERD_FAULT) begin
      stb.finError = 1'b1;
      stateNext    = ST_IDLE;
      phaseNext    = '0;
    end else if (rdyValid) begin
      stb.finDone = 1'b1;
      stateNext   = ST_IDLE;
      phaseNext   = '0;
    end else if (toExpire) begin
      stb.finTimeout = 1'b1;
      stateNext      = ST_IDLE;
      phaseNext      = '0;
    end else begin
      unique case (state)
        ST_SETUP: begin
          if (phaseCnt == PHASE_W'(SETUP_CYC - 1)) begin
            stateNext = ST_READ;
            phaseNext = '0;
          end else begin
            phaseNext = phaseCnt + 1'b1;
          end
        end
        ST_READ: begin
          if (samplePoint) begin
            stateNext = ST_GAP;
            phaseNext = '0;
          end else begin
            phaseNext = phaseCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (phaseCnt == PHASE_W'(HIGH_CYC - 1)) begin
            stateNext = ST_READ;
            phaseNext = '0;
          end else begin
            phaseNext = phaseCnt + 1'b1;
          end
        end
        default: begin
          stateNext = ST_IDLE;
          phaseNext = '0;
        end
      endcase
    end
  end

  assign flashCeN = (state == ST_IDLE);
  assign flashOeN = (state != ST_READ);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/flash_toggle_poller.sv
`timescale 1ns/1ps
module flash_toggle_poller
  import tpoll_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int DATA_W          = 16,
  parameter int CLK_PERIOD_PS   = 8000,
  parameter int ADDR_SETUP_PS   = 15000,
  parameter int OE_HIGH_PS      = 20000,
  parameter int OE_DELAY_PS     = 25000,
  parameter int RDY_IGNORE_PS   = 90000,
  parameter int WORD_LIMIT_PS   = 175000000,
  parameter int BUFFER_LIMIT_PS = 250000000,
  parameter int TOGGLE_BIT      = 6,
  parameter int FAULT_BIT       = 5,
  parameter int CONFIRM_READS   = 2,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opBuffer,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] dqIn,
  input  logic              rdyBusyN,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timeout
);

  localparam int SETUP_CYC   = cyclesFor(ADDR_SETUP_PS, CLK_PERIOD_PS);
  localparam int HIGH_CYC    = cyclesFor(OE_HIGH_PS, CLK_PERIOD_PS);
  localparam int ACCESS_CYC  = cyclesFor(OE_DELAY_PS, CLK_PERIOD_PS);
  localparam int IGN_CYC     = cyclesFor(RDY_IGNORE_PS, CLK_PERIOD_PS);
  localparam int TO_WORD_CYC = cyclesFor(WORD_LIMIT_PS, CLK_PERIOD_PS);
  localparam int TO_BUF_CYC  = cyclesFor(BUFFER_LIMIT_PS, CLK_PERIOD_PS);
  localparam int PHASE_W     = $clog2(maxOf3(SETUP_CYC, HIGH_CYC, ACCESS_CYC) + 1);
  localparam int TO_W        = $clog2(maxOf3(TO_WORD_CYC, TO_BUF_CYC, 1) + 1);
  localparam int IGN_W       = $clog2(IGN_CYC + 1);

  dpStrobe_t stb;
  verdict_t  verdict;
  logic      rdyValid;
  logic      toExpire;

  tpoll_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .PHASE_W   (PHASE_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .verdict (verdict),
    .rdyValid(rdyValid),
    .toExpire(toExpire),
    .stb     (stb),
    .flashCeN(flashCeN),
    .flashOeN(flashOeN),
    .busy    (busy)
  );

  tpoll_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .TOGGLE_BIT   (TOGGLE_BIT),
    .FAULT_BIT    (FAULT_BIT),
    .CONFIRM_READS(CONFIRM_READS),
    .SYNC_STAGES  (SYNC_STAGES),
    .IGN_CYC      (IGN_CYC),
    .TO_WORD_CYC  (TO_WORD_CYC),
    .TO_BUF_CYC   (TO_BUF_CYC),
    .TO_W         (TO_W),
    .IGN_W        (IGN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .opBuffer (opBuffer),
    .pollAddr (pollAddr),
    .dqIn     (dqIn),
    .rdyBusyN (rdyBusyN),
    .flashAddr(flashAddr),
    .verdict  (verdict),
    .rdyValid (rdyValid),
    .toExpire (toExpire),
    .done     (done),
    .error    (error),
    .timeout  (timeout)
  );

endmodule

// File: rtl/tpoll_checker.sv
`timescale 1ns/1ps
module tpoll_checker #(
  parameter int ADDR_W    = 24,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              timeout
);

  logic [15:0] hiRun;
  logic [15:0] ceLowRun;
  logic        readSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= '0;
      ceLowRun <= '0;
      readSeen <= 1'b0;
    end else begin
      if (!flashOeN)              hiRun <= '0;
      else if (hiRun != 16'hFFFF) hiRun <= hiRun + 1'b1;
      if (flashCeN)                  ceLowRun <= '0;
      else if (ceLowRun != 16'hFFFF) ceLowRun <= ceLowRun + 1'b1;
      if (flashCeN)       readSeen <= 1'b0;
      else if (!flashOeN) readSeen <= 1'b1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (flashCeN && flashOeN));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(flashAddr)));

  p_setup_first_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashOeN) |-> (ceLowRun >= 16'(SETUP_CYC)));

  p_oe_inside_ce_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashCeN);

  p_oe_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashOeN) && readSeen) |-> (hiRun >= 16'(HIGH_CYC)));

  p_pins_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done || error || timeout) |-> (flashCeN && flashOeN && !busy));

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, error, timeout}));

  p_end_has_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error || timeout));

endmodule

bind flash_toggle_poller tpoll_checker #(
  .ADDR_W   (ADDR_W),
  .SETUP_CYC(SETUP_CYC),
  .HIGH_CYC (HIGH_CYC)
) u_tpollChk (
  .clk      (clk),
  .rstN     (rstN),
  .flashCeN (flashCeN),
  .flashOeN (flashOeN),
  .flashAddr(flashAddr),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .timeout  (timeout)
);

// File: tb/flash_toggle_poller_test.sv
`timescale 1ns/1ps
module flash_toggle_poller_test;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic              opBuffer;
  logic [ADDR_W-1:0] pollAddr;
  logic [DATA_W-1:0] dqIn;
  logic              rdyBusyN;
  logic              flashCeN;
  logic              flashOeN;
  logic [ADDR_W-1:0] flashAddr;
  logic              busy;
  logic              done;
  logic              error;
  logic              timeout;

  always #4 clk = ~clk;

  flash_toggle_poller uut (
    .clk(clk), .rstN(rstN), .start(start), .opBuffer(opBuffer),
    .pollAddr(pollAddr), .dqIn(dqIn), .rdyBusyN(rdyBusyN),
    .flashCeN(flashCeN), .flashOeN(flashOeN), .flashAddr(flashAddr),
    .busy(busy), .done(done), .error(error), .timeout(timeout)
  );

  int errors = 0;
  int checks = 0;

  // flash status model: bit 6 flips per read until stopAt reads, bit 5 fixed
  int          readCnt = 0;
  int          stopAt  = 1;
  logic        faultBit = 1'b0;
  logic [DATA_W-1:0] dqModel = '0;

  function automatic logic [DATA_W-1:0] modelWord(input int idx);
    logic [DATA_W-1:0] w;
    int k;
    w = DATA_W'(idx * 32'h2B5 + 32'h91);
    k = (idx < stopAt) ? idx : stopAt - 1;
    if (k < 0) k = 0;
    w[6] = (k % 2) == 1;
    w[5] = faultBit;
    return w;
  endfunction

  always @(negedge flashOeN) begin
    dqModel = modelWord(readCnt);
    readCnt = readCnt + 1;
  end

  assign dqIn = dqModel;

  // pin-timing monitor
  int   hiRun = 0;
  int   setupSeen = -1;
  int   minGap = 1000;
  int   addrBad = 0;
  logic readSeen = 1'b0;
  logic [ADDR_W-1:0] expAddr = '0;

  always @(negedge clk) begin
    if (rstN && !flashCeN) begin
      if (flashAddr !== expAddr) addrBad = addrBad + 1;
      if (flashOeN) hiRun = hiRun + 1;
      else begin
        if (hiRun > 0) begin
          if (readSeen) begin
            if (hiRun < minGap) minGap = hiRun;
          end else setupSeen = hiRun;
        end
        hiRun = 0;
        readSeen = 1'b1;
      end
    end else begin
      hiRun = 0;
      readSeen = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input longint act, input longint exp);
    check(act == exp, tag, act, exp);
  endtask

  // returns just after the start edge (E0)
  task automatic launch(input logic [ADDR_W-1:0] a, input logic b, input int stop, input logic f);
    @(negedge clk);
    stopAt   = stop;
    faultBit = f;
    readCnt  = 0;
    expAddr  = a;
    minGap   = 1000;
    setupSeen = -1;
    pollAddr = a;
    opBuffer = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic test_reset();
    checkEq("R1 ceN after reset", flashCeN, 1);
    checkEq("R1 oeN after reset", flashOeN, 1);
    checkEq("R1 busy after reset", busy, 0);
    checkEq("R1 flags after reset", {done, error, timeout}, 0);
  endtask

  task automatic test_quick_settle();
    launch(24'h12_3456, 1'b0, 1, 1'b0);
    repeat (1) @(negedge clk);
    checkEq("R2 busy set", busy, 1);
    checkEq("R2 address latched", flashAddr, 24'h12_3456);
    checkEq("R3 ceN low after start", flashCeN, 0);
    checkEq("R3 oeN still high in setup", flashOeN, 1);
    repeat (1) @(negedge clk);
    checkEq("R3 oeN low after setup", flashOeN, 0);
    repeat (3) @(negedge clk);
    checkEq("R5 oeN low through access", flashOeN, 0);
    repeat (1) @(negedge clk);
    checkEq("R5 oeN high after capture", flashOeN, 1);
    checkEq("R6 single read not done", done, 0);
    repeat (6) @(negedge clk);
    checkEq("R6 done not before second capture", done, 0);
    repeat (1) @(negedge clk);
    checkEq("R6 done on second capture", done, 1);
    checkEq("R6 ceN released", flashCeN, 1);
    checkEq("R6 busy cleared", busy, 0);
    checkEq("R6 read count", readCnt, 2);
    checkEq("R3 setup cycles before first read", setupSeen, 2);
  endtask

  task automatic test_toggle_settle();
    launch(24'hA5_0F0F, 1'b0, 3, 1'b0);
    repeat (26) @(negedge clk);
    checkEq("R6 not done while toggling", done, 0);
    repeat (1) @(negedge clk);
    checkEq("R6 done after settle", done, 1);
    checkEq("R6 read count settle", readCnt, 4);
    check(minGap >= 3, "R4 oe high gap", minGap, 3);
    checkEq("R2 address stable", addrBad, 0);
  endtask

  task automatic test_fault_error();
    launch(24'h00_0040, 1'b0, 100000, 1'b1);
    repeat (26) @(negedge clk);
    checkEq("R7 no error before last confirm", error, 0);
    checkEq("R7 busy before last confirm", busy, 1);
    repeat (1) @(negedge clk);
    checkEq("R7 error after two confirms", error, 1);
    checkEq("R7 done clear on error", done, 0);
    checkEq("R7 ceN released on error", flashCeN, 1);
    checkEq("R7 read count error", readCnt, 4);
  endtask

  task automatic test_fault_recover();
    launch(24'h3F_FFFF, 1'b0, 3, 1'b1);
    repeat (26) @(negedge clk);
    checkEq("R7 recover no early done", done, 0);
    repeat (1) @(negedge clk);
    checkEq("R7 recover done", done, 1);
    checkEq("R7 recover no error", error, 0);
    checkEq("R7 recover read count", readCnt, 4);
  endtask

  task automatic test_ready_window();
    rdyBusyN = 1'b1;
    launch(24'h00_1000, 1'b0, 100000, 1'b0);
    repeat (12) @(negedge clk);
    checkEq("R8 ready ignored in window", done, 0);
    checkEq("R8 busy in window", busy, 1);
    repeat (1) @(negedge clk);
    checkEq("R8 ready honoured after window", done, 1);
    checkEq("R8 no error", error, 0);
    rdyBusyN = 1'b0;
  endtask

  task automatic test_word_timeout();
    launch(24'h55_AA55, 1'b0, 100000, 1'b0);
    repeat (5) @(negedge clk);
    pollAddr = 24'h77_7777;
    opBuffer = 1'b1;
    start    = 1'b1;
    repeat (1) @(negedge clk);
    start    = 1'b0;
    checkEq("R2 start while busy ignored", flashAddr, 24'h55_AA55);
    repeat (21868) @(negedge clk);
    checkEq("R9 word no early timeout", timeout, 0);
    checkEq("R9 word still busy", busy, 1);
    repeat (1) @(negedge clk);
    checkEq("R9 word timeout", timeout, 1);
    checkEq("R9 ceN released", flashCeN, 1);
    checkEq("R9 oeN released", flashOeN, 1);
    checkEq("R10 only timeout", {done, error}, 0);
    checkEq("R2 address held", addrBad, 0);
    repeat (5) @(negedge clk);
    checkEq("R10 timeout held", timeout, 1);
  endtask

  task automatic test_buffer_timeout();
    launch(24'h01_0203, 1'b1, 100000, 1'b0);
    repeat (31249) @(negedge clk);
    checkEq("R9 buffer no early timeout", timeout, 0);
    repeat (1) @(negedge clk);
    checkEq("R9 buffer timeout", timeout, 1);
  endtask

  task automatic test_flag_clear();
    launch(24'h0A_0B0C, 1'b0, 1, 1'b0);
    repeat (1) @(negedge clk);
    checkEq("R10 flags cleared by start", {done, error, timeout}, 0);
    checkEq("R10 busy on new op", busy, 1);
    repeat (12) @(negedge clk);
    checkEq("R10 done on new op", done, 1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    finishRun();
  end

  initial begin
    rstN     = 1'b0;
    start    = 1'b0;
    opBuffer = 1'b0;
    pollAddr = '0;
    rdyBusyN = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R1 ceN in reset", flashCeN, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_quick_settle();
    test_toggle_settle();
    test_fault_error();
    test_fault_recover();
    test_ready_window();
    test_word_timeout();
    test_buffer_timeout();
    test_flag_clear();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule